// File: doc/BRIEF.md
# Thread-aware DRAM request scheduler

This block sits between the cores of a multithreaded processor and a DRAM command sequencer. It accepts memory requests through a valid/ready handshake and parks them in an eight-slot holding pool. Each request carries a hardware thread number, a write flag, a bank number and a row number. Every cycle the block offers the single best parked request on its issue port. The sequencer takes that request by raising its accept input, and the slot becomes free on the same clock edge.

The ranking uses four keys in a fixed order. A request that hits the row currently open in its bank comes first. After that, reads beat writes. Next comes a thread-aware key chosen by a configuration input, and the older request breaks any remaining tie. The thread-aware key is one of three measures. The first is the number of requests the thread still has pending, where fewer ranks higher. The second is the thread's share of reorder-buffer entries, where more ranks higher. The third is the thread's share of issue-queue entries, where more also ranks higher. The two occupancy measures are supplied as inputs. The block keeps a table of the open row in each bank. A close-page setting makes every access close its row.

Each slot is a two-state machine with the states SLOT_FREE and SLOT_HELD. The transition *fill* (SLOT_FREE to SLOT_HELD) happens when an offered request is accepted into the lowest free slot. The transition *take* (SLOT_HELD to SLOT_FREE) happens when the slot's request is issued.

Top module: `tarb_sched`

## Requirements
- R1: `req_rdy_o` is 0 exactly when all 8 slots are held. A request is stored only on a cycle with `req_vld_i` and `req_rdy_o` both 1, and a request offered while `req_rdy_o` is 0 is never stored or issued.
- R2: `iss_vld_o` is 1 whenever at least one request is held, and the issue port shows the selected request. It issues on an edge where `iss_vld_o` and `iss_rdy_i` are both 1, its slot frees on that edge, and each accepted request issues exactly once.
- R3: A request hits when its bank has an open row equal to its row. A held hit always ranks above a held miss, and `iss_hit_o` reports whether the shown request hits.
- R4: Among requests equal on hit status, a read (`req_wr_i`=0) ranks above a write (`req_wr_i`=1).
- R5: With `cfg_policy_i` = 2'b00 or 2'b11, a thread with fewer pending requests ranks higher. The pending count of a thread rises by one on each accepted request and falls by one on each issued request.
- R6: With `cfg_policy_i` = 2'b01, a thread whose reorder-buffer count is larger ranks higher. The count for thread t is `rob_occ_i[t*6 +: 6]`.
- R7: With `cfg_policy_i` = 2'b10, a thread whose issue-queue count is larger ranks higher. The count for thread t is `iq_occ_i[t*6 +: 6]`.
- R8: When hit, read and thread keys are all equal, the longer-waiting request ranks higher. A still-remaining tie goes to the lowest slot.
- R9: After reset no bank has an open row. With `cfg_close_i`=0, issuing a request opens its row in its bank.
- R10: With `cfg_close_i`=1, issuing a request leaves its bank with no open row, and `iss_hit_o` is 0.
- R11: An acceptance and an issue may fall on the same edge, and both take effect, including on the pending count of a thread that is both enqueuing and issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_policy_i | input | 2 | Thread key: 00/11 pending count, 01 reorder-buffer share, 10 issue-queue share |
| cfg_close_i | input | 1 | 1 selects close-page operation |
| rob_occ_i | input | 24 | Per-thread reorder-buffer entry counts, 6 bits per thread |
| iq_occ_i | input | 24 | Per-thread issue-queue entry counts, 6 bits per thread |
| req_vld_i | input | 1 | Request offered |
| req_rdy_o | output | 1 | A free slot exists |
| req_tid_i | input | 2 | Thread number of the offered request |
| req_wr_i | input | 1 | 1 for write, 0 for read |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | 8 | Target row |
| iss_vld_o | output | 1 | A request is on the issue port |
| iss_rdy_i | input | 1 | Sequencer takes the shown request |
| iss_tid_o | output | 2 | Thread of the shown request |
| iss_wr_o | output | 1 | Write flag of the shown request |
| iss_bank_o | output | 2 | Bank of the shown request |
| iss_row_o | output | 8 | Row of the shown request |
| iss_hit_o | output | 1 | The shown request hits the open row |

## Verification
Acceptance and issue can land on the same edge. When both belong to one thread, that thread's pending counter sees an increment and a decrement at once. The bench parks three requests from one thread and then raises offer and accept together for one cycle. It then parks three requests from a second thread. The next issues are judged in the scoreboard. With a correct net count the two threads tie and age picks the first thread's oldest request. With a lost increment or a lost decrement the counts differ, and the order comes out wrong.

// File: rtl/tarb_pkg.sv
package tarb_pkg;

    typedef enum logic [1:0] {
        POL_PENDING = 2'd0,
        POL_ROB     = 2'd1,
        POL_IQ      = 2'd2,
        POL_SPARE   = 2'd3
    } policy_e;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/tarb_slot.sv
module tarb_slot
    import tarb_pkg::*;
#(
    parameter int TID_W  = 2,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int AGE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic              take,
    input  logic [TID_W-1:0]  in_tid,
    input  logic              in_wr,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [ROW_W-1:0]  in_row,
    output logic              held,
    output logic [TID_W-1:0]  tid,
    output logic              wr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [AGE_W-1:0]  age
);

    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (fill) state_d = SLOT_HELD;
            SLOT_HELD: if (take) state_d = SLOT_FREE;
            default:   state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tid  <= '0;
            wr   <= 1'b0;
            bank <= '0;
            row  <= '0;
            age  <= '0;
        end else if (fill) begin
            tid  <= in_tid;
            wr   <= in_wr;
            bank <= in_bank;
            row  <= in_row;
            age  <= '0;
        end else if (state_q == SLOT_HELD && age != '1) begin
            age  <= age + 1'b1;
        end
    end

    assign held = (state_q == SLOT_HELD);

    AST_FILL_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> state_q == SLOT_FREE); // R1
    AST_TAKE_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> state_q == SLOT_HELD); // R2

endmodule

// File: rtl/tarb_rowtrk.sv
module tarb_rowtrk #(
    parameter int BANKS  = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              close_pg,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] q_bank [DEPTH],
    input  logic [ROW_W-1:0]  q_row  [DEPTH],
    output logic [DEPTH-1:0]  q_hit
);

    logic [BANKS-1:0] open_vld_q;
    logic [ROW_W-1:0] open_row_q [BANKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld_q <= '0;
            for (int b = 0; b < BANKS; b++) open_row_q[b] <= '0;
        end else if (upd) begin
            open_vld_q[upd_bank] <= !close_pg;
            open_row_q[upd_bank] <= upd_row;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            q_hit[i] = !close_pg && open_vld_q[q_bank[i]] &&
                       (open_row_q[q_bank[i]] == q_row[i]);
        end
    end

    AST_OPEN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        upd && !close_pg |=> open_vld_q[$past(upd_bank)] &&
                             open_row_q[$past(upd_bank)] == $past(upd_row)); // R9
    AST_CLOSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        upd && close_pg |=> !open_vld_q[$past(upd_bank)]); // R10

endmodule

// File: rtl/tarb_pick.sv
module tarb_pick #(
    parameter int DEPTH  = 8,
    parameter int KEY_W  = 12,
    parameter int SLOT_W = 3
) (
    input  logic [DEPTH-1:0]  held,
    input  logic [KEY_W-1:0]  key [DEPTH],
    output logic              any,
    output logic [SLOT_W-1:0] idx
);

    logic [KEY_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (held[i] && (!any || key[i] > best)) begin
                any  = 1'b1;
                idx  = SLOT_W'(i);
                best = key[i];
            end
        end
    end

endmodule

// File: rtl/tarb_sched.sv
module tarb_sched
    import tarb_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int THREADS = 4,
    parameter int BANKS   = 4,
    parameter int ROW_W   = 8,
    parameter int AGE_W   = 4,
    parameter int OCC_W   = 6,
    localparam int TID_W   = $clog2(THREADS),
    localparam int BANK_W  = $clog2(BANKS),
    localparam int SLOT_W  = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int SCORE_W = (OCC_W > CNT_W) ? OCC_W : CNT_W,
    localparam int KEY_W   = 2 + SCORE_W + AGE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_policy_i,
    input  logic                     cfg_close_i,
    input  logic [THREADS*OCC_W-1:0] rob_occ_i,
    input  logic [THREADS*OCC_W-1:0] iq_occ_i,
    input  logic                     req_vld_i,
    output logic                     req_rdy_o,
    input  logic [TID_W-1:0]         req_tid_i,
    input  logic                     req_wr_i,
    input  logic [BANK_W-1:0]        req_bank_i,
    input  logic [ROW_W-1:0]         req_row_i,
    output logic                     iss_vld_o,
    input  logic                     iss_rdy_i,
    output logic [TID_W-1:0]         iss_tid_o,
    output logic                     iss_wr_o,
    output logic [BANK_W-1:0]        iss_bank_o,
    output logic [ROW_W-1:0]         iss_row_o,
    output logic                     iss_hit_o
);

    logic [DEPTH-1:0]   held, fill_v, take_v, slot_wr, slot_hit;
    logic [TID_W-1:0]   slot_tid  [DEPTH];
    logic [BANK_W-1:0]  slot_bank [DEPTH];
    logic [ROW_W-1:0]   slot_row  [DEPTH];
    logic [AGE_W-1:0]   slot_age  [DEPTH];
    logic [SCORE_W-1:0] slot_score[DEPTH];
    logic [KEY_W-1:0]   slot_key  [DEPTH];
    logic [CNT_W-1:0]   pend_q    [THREADS];
    logic [SLOT_W-1:0]  pick_idx;
    logic               accept, take, found;

    assign req_rdy_o = !(&held);
    assign accept    = req_vld_i && req_rdy_o;
    assign take      = iss_vld_o && iss_rdy_i;
    assign take_v    = DEPTH'(take) << pick_idx;

    // lowest free slot receives the accepted request
    always_comb begin
        fill_v = '0;
        found  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!held[i] && !found) begin
                fill_v[i] = accept;
                found     = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        tarb_slot #(
            .TID_W(TID_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)
        ) slot_i (
            .clk(clk), .rst_n(rst_n), .fill(fill_v[g]), .take(take_v[g]),
            .in_tid(req_tid_i), .in_wr(req_wr_i), .in_bank(req_bank_i),
            .in_row(req_row_i), .held(held[g]), .tid(slot_tid[g]),
            .wr(slot_wr[g]), .bank(slot_bank[g]), .row(slot_row[g]),
            .age(slot_age[g])
        );
    end

    // per-thread pending counters
    for (genvar t = 0; t < THREADS; t++) begin : g_pend
        logic inc, dec;
        assign inc = accept && (req_tid_i == TID_W'(t));
        assign dec = take && (iss_tid_o == TID_W'(t));
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_q[t] <= '0;
            else if (inc && !dec) pend_q[t] <= pend_q[t] + 1'b1;
            else if (dec && !inc) pend_q[t] <= pend_q[t] - 1'b1;
        end
        AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[t] <= CNT_W'(DEPTH)); // R5
    end

    // thread-aware score, larger is better
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            unique case (policy_e'(cfg_policy_i))
                POL_ROB: slot_score[i] = SCORE_W'(rob_occ_i[slot_tid[i]*OCC_W +: OCC_W]);
                POL_IQ:  slot_score[i] = SCORE_W'(iq_occ_i[slot_tid[i]*OCC_W +: OCC_W]);
                default: slot_score[i] = SCORE_W'(CNT_W'(DEPTH) - pend_q[slot_tid[i]]);
            endcase
            slot_key[i] = {slot_hit[i], !slot_wr[i], slot_score[i], slot_age[i]};
        end
    end

    tarb_rowtrk #(
        .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .DEPTH(DEPTH)
    ) rowtrk_i (
        .clk(clk), .rst_n(rst_n), .upd(take), .close_pg(cfg_close_i),
        .upd_bank(iss_bank_o), .upd_row(iss_row_o),
        .q_bank(slot_bank), .q_row(slot_row), .q_hit(slot_hit)
    );

    tarb_pick #(
        .DEPTH(DEPTH), .KEY_W(KEY_W), .SLOT_W(SLOT_W)
    ) pick_i (
        .held(held), .key(slot_key), .any(iss_vld_o), .idx(pick_idx)
    );

    assign iss_tid_o  = slot_tid[pick_idx];
    assign iss_wr_o   = slot_wr[pick_idx];
    assign iss_bank_o = slot_bank[pick_idx];
    assign iss_row_o  = slot_row[pick_idx];
    assign iss_hit_o  = slot_hit[pick_idx];

    logic [CNT_W+TID_W:0] pend_sum;
    always_comb begin
        pend_sum = '0;
        for (int t = 0; t < THREADS; t++) pend_sum = pend_sum + (CNT_W+TID_W+1)'(pend_q[t]);
    end

    AST_PEND_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pend_q[iss_tid_o] != '0); // R5
    AST_PEND_MATCHES_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_sum) == $countones(held)); // R11

    for (genvar g = 0; g < DEPTH; g++) begin : g_order_chk
        AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            iss_vld_o && held[g] && slot_hit[g] |-> iss_hit_o); // R3
        AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            iss_vld_o && held[g] && (slot_hit[g] == iss_hit_o) && !slot_wr[g]
            |-> !iss_wr_o); // R4
    end

endmodule

// File: tb/tarb_sched_tb_top.sv
module tarb_sched_tb_top;

    typedef struct {
        int       tag;
        int       tid;
        int       wr;
        int       bank;
        int       row;
        int       hit;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_policy = 2'b00;
    logic        cfg_close = 1'b0;
    logic [23:0] rob_occ = '0;
    logic [23:0] iq_occ = '0;
    logic        req_vld = 1'b0;
    logic        req_rdy;
    logic [1:0]  req_tid = '0;
    logic        req_wr = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [7:0]  req_row = '0;
    logic        iss_vld;
    logic        iss_rdy = 1'b0;
    logic [1:0]  iss_tid;
    logic        iss_wr;
    logic [1:0]  iss_bank;
    logic [7:0]  iss_row;
    logic        iss_hit;

    int checks = 0;
    int failures = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    tarb_sched dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_policy_i(cfg_policy), .cfg_close_i(cfg_close),
        .rob_occ_i(rob_occ), .iq_occ_i(iq_occ), .req_vld_i(req_vld), .req_rdy_o(req_rdy),
        .req_tid_i(req_tid), .req_wr_i(req_wr), .req_bank_i(req_bank), .req_row_i(req_row),
        .iss_vld_o(iss_vld), .iss_rdy_i(iss_rdy), .iss_tid_o(iss_tid), .iss_wr_o(iss_wr),
        .iss_bank_o(iss_bank), .iss_row_o(iss_row), .iss_hit_o(iss_hit)
    );

    task automatic check(input string req, input int got, input int exp, input string what);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic push(input int tag, input int tid, input int wr, input int bank,
                        input int row, input int hit);
        exp_t e;
        e.tag = tag; e.tid = tid; e.wr = wr; e.bank = bank; e.row = row; e.hit = hit;
        sb.push_back(e);
    endtask

    // driver: inputs change 1 ns after a rising edge
    task automatic enq(input int tid, input int wr, input int bank, input int row);
        req_vld = 1'b1; req_tid = 2'(tid); req_wr = 1'(wr);
        req_bank = 2'(bank); req_row = 8'(row);
        @(posedge clk); #1;
        req_vld = 1'b0;
    endtask

    task automatic drain(input int n);
        iss_rdy = 1'b1;
        repeat (n) @(posedge clk);
        #1 iss_rdy = 1'b0;
    endtask

    // monitor: compares every issued request against the scoreboard
    always @(negedge clk) begin
        if (rst_n && iss_vld && iss_rdy) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected issue: got tid=%0d row=%0d expected none",
                         iss_tid, iss_row);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (int'(iss_tid) != e.tid || int'(iss_wr) != e.wr ||
                    int'(iss_bank) != e.bank || int'(iss_row) != e.row ||
                    int'(iss_hit) != e.hit) begin
                    failures++;
                    $display("FAIL R%0d issue: got tid=%0d wr=%0d bank=%0d row=%0d hit=%0d expected tid=%0d wr=%0d bank=%0d row=%0d hit=%0d",
                             e.tag, iss_tid, iss_wr, iss_bank, iss_row, iss_hit,
                             e.tid, e.wr, e.bank, e.row, e.hit);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(req_rdy), 1, "ready after reset");
        check("R2", int'(iss_vld), 0, "issue valid after reset");
        @(posedge clk); #1;

        // R9: first access to bank 0 misses, then it stays open
        push(9, 0, 0, 0, 5, 0);
        enq(0, 0, 0, 5); drain(1);
        // R3: hit beats an older miss
        enq(0, 0, 0, 7); enq(0, 0, 0, 5);
        push(3, 0, 0, 0, 5, 1);
        push(3, 0, 0, 0, 7, 0);
        drain(2);

        // R4: read beats older write
        enq(1, 1, 1, 1); enq(1, 0, 1, 2);
        push(4, 1, 0, 1, 2, 0);
        push(4, 1, 1, 1, 1, 0);
        drain(2);

        // R8: equal keys, older first
        enq(2, 0, 2, 3); enq(2, 0, 2, 4);
        push(8, 2, 0, 2, 3, 0);
        push(8, 2, 0, 2, 4, 0);
        drain(2);

        // R5: thread with fewer pending first
        enq(0, 0, 3, 1); enq(0, 0, 3, 2); enq(1, 0, 3, 3);
        push(5, 1, 0, 3, 3, 0);
        push(5, 0, 0, 3, 1, 0);
        push(5, 0, 0, 3, 2, 0);
        drain(3);

        // R6: reorder-buffer share, more first
        cfg_policy = 2'b01;
        rob_occ = {6'd0, 6'd0, 6'd9, 6'd2};
        enq(0, 0, 3, 10); enq(1, 0, 3, 11);
        push(6, 1, 0, 3, 11, 0);
        push(6, 0, 0, 3, 10, 0);
        drain(2);

        // R4: read-first outranks the thread key
        enq(1, 1, 1, 50); enq(0, 0, 1, 51);
        push(4, 0, 0, 1, 51, 0);
        push(4, 1, 1, 1, 50, 0);
        drain(2);

        // R7: issue-queue share, more first
        cfg_policy = 2'b10;
        iq_occ = {6'd0, 6'd0, 6'd1, 6'd12};
        enq(0, 0, 3, 20); enq(1, 0, 3, 21);
        push(7, 0, 0, 3, 20, 0);
        push(7, 1, 0, 3, 21, 0);
        drain(2);
        cfg_policy = 2'b00;

        // R10: close page, bank 0 row 7 was open but reports no hit
        cfg_close = 1'b1;
        push(10, 0, 0, 0, 7, 0);
        enq(0, 0, 0, 7); drain(1);
        enq(0, 0, 0, 9); enq(0, 0, 0, 9);
        push(10, 0, 0, 0, 9, 0);
        push(10, 0, 0, 0, 9, 0);
        drain(2);
        cfg_close = 1'b0;
        // R9: bank closed, so first open-page access misses, second hits
        push(9, 0, 0, 0, 9, 0);
        enq(0, 0, 0, 9); drain(1);
        push(9, 0, 0, 0, 9, 1);
        enq(0, 0, 0, 9); drain(1);

        // R1: fill all slots, offered extra must not be stored
        for (int i = 0; i < 8; i++) enq(0, 0, 2, 60 + i);
        @(negedge clk);
        check("R1", int'(req_rdy), 0, "ready when full");
        @(posedge clk); #1;
        req_vld = 1'b1; req_tid = 2'd3; req_wr = 1'b0; req_bank = 2'd2; req_row = 8'd99;
        repeat (2) @(posedge clk);
        #1 req_vld = 1'b0;
        @(negedge clk);
        check("R1", int'(req_rdy), 0, "ready still low after refused offer");
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) push(2, 0, 0, 2, 60 + i, 0);
        drain(9);
        @(negedge clk);
        check("R1", int'(req_rdy), 1, "ready after drain");
        check("R2", int'(iss_vld), 0, "issue valid after drain");
        @(posedge clk); #1;

        // R11: same-edge enqueue and issue on one thread's counter
        enq(3, 0, 0, 30); enq(3, 0, 0, 31); enq(3, 0, 0, 32);
        push(11, 3, 0, 0, 30, 0);
        req_vld = 1'b1; req_tid = 2'd3; req_wr = 1'b0; req_bank = 2'd0; req_row = 8'd33;
        iss_rdy = 1'b1;
        @(posedge clk); #1;
        req_vld = 1'b0; iss_rdy = 1'b0;
        enq(2, 0, 0, 40); enq(2, 0, 0, 41); enq(2, 0, 0, 42);
        push(11, 3, 0, 0, 31, 0);
        push(5, 3, 0, 0, 32, 0);
        push(5, 3, 0, 0, 33, 0);
        push(11, 2, 0, 0, 40, 0);
        push(11, 2, 0, 0, 41, 0);
        push(11, 2, 0, 0, 42, 0);
        drain(6);

        @(negedge clk);
        check("R2", sb.size(), 0, "scoreboard items left");
        check("R2", int'(iss_vld), 0, "issue valid at end");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule